// File: doc/BRIEF.md
# Boot Remap Address Decoder

This block sits between the processor's address bus and the memory system. For every valid access it decodes the 32-bit address. The access goes to boot memory, to internal SRAM, to the internal peripheral space, or to one of eight external chip-select banks. A region can also go unselected. A one-way remap flag decides which memory answers at the bottom of the address space, where the exception vectors live. Boot memory answers there out of reset, and SRAM answers there once software has issued the remap command.

The same flag gates external chip selects 1 to 7, so those devices cannot be reached until the vector area has been moved. An access that lands in the external window and matches no permitted bank produces a one-cycle abort. The abort is reported as a prefetch abort for instruction fetches and as a data abort otherwise. Internal addresses never abort.

Each bank is programmed through a small register port with a base address, a power-of-two size and an enable. The remap flag is readable through the same port. All decode outputs are registered and appear in the clock cycle after the access is presented.

Top module: `bootmap_decoder`

## Requirements
- R1: While the remap flag is clear, a valid access in 0x0000_0000..0x000F_FFFF raises `sel_boot`. While it is set, the same access raises `sel_sram` instead.
- R2: A register write with `reg_idx` = 0 and `reg_wdata[0]` = 1 sets the remap flag. A write of 0 to that bit leaves the flag unchanged. Reading index 0 returns the flag in bit 0 and zero elsewhere.
- R3: Once set, the remap flag stays set under any register write and is cleared only by `rst_n` going low.
- R4: `cs_o[7:1]` are never asserted while the remap flag is clear, and an access that would hit one of those banks is treated as undefined. `cs_o[0]` may be asserted at any time.
- R5: Register index k+1 programs bank k. Bits [31:20] hold the base, bit 3 is the enable, and bits [2:0] are the size code, giving a size of 1 MiB << code. Codes above 4 are stored and read back as 4, and the other bits read as zero. A bank hits when it is enabled and the address bits above the size agree with the base. When enabled banks overlap, the lowest index wins.
- R6: A valid access with 0x0040_0000 <= address < 0xFFC0_0000 that selects no chip select raises `abt_prefetch` when `acc_fetch` = 1 and `abt_data` when `acc_fetch` = 0, never both.
- R7: An access at or above 0xFFC0_0000 raises `sel_periph` and never an abort. No address below 0x0040_0000 ever aborts.
- R8: Outputs follow the access by one clock. After a clock edge at which `acc_valid` was low, every select and abort output is zero, so each abort is a single-cycle pulse.
- R9: 0x0010_0000..0x001F_FFFF always selects SRAM and 0x0020_0000..0x002F_FFFF always selects boot memory, whatever the remap flag. 0x0030_0000..0x003F_FFFF selects nothing and does not abort.
- R10: After reset all outputs are zero, the remap flag is clear and every bank register reads zero (disabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| acc_addr | input | 32 | Access address |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index: 0 remap control, 1..8 bank 0..7 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational readback of register `reg_idx` |
| sel_boot | output | 1 | Boot memory selected |
| sel_sram | output | 1 | Internal SRAM selected |
| sel_periph | output | 1 | Internal peripheral space selected |
| cs_o | output | 8 | External chip selects, at most one high |
| abt_prefetch | output | 1 | Abort pulse for an instruction fetch |
| abt_data | output | 1 | Abort pulse for a data access |

## Verification
The properties assume that `rst_n` is asserted before the first clock so that every register starts from its reset value. They also assume that `reg_idx`, `reg_wdata` and `reg_wr` are stable around the sampling edge. The stimulus sets every input at the falling edge and holds it for a full cycle. It resets the block before any access and again later to show the flag clearing. It only programs bank bases that are aligned to their size, which matches how the match logic ignores the bits below the size.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;

   // Fixed internal region hits for one decoded address.
   typedef struct packed {
      logic low;
      logic sram;
      logic boot;
      logic ext;
      logic periph;
   } int_rgn_t;

endpackage

// File: rtl/bootmap_cfg_regs.sv
module bootmap_cfg_regs #(
   parameter int ADDR_W    = 32,
   parameter int N_CS      = 8,
   parameter int GRAN_BITS = 20,
   parameter int SZ_W      = 3,
   parameter int SZ_MAX    = 4,
   localparam int BASE_W   = ADDR_W - GRAN_BITS,
   localparam int IDX_W    = $clog2(N_CS + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              idx,
   input  logic [ADDR_W-1:0]             wr_data,
   output logic [ADDR_W-1:0]             rd_data,
   output logic                          remap_o,
   output logic [N_CS-1:0][BASE_W-1:0]   base_o,
   output logic [N_CS-1:0][SZ_W-1:0]     code_o,
   output logic [N_CS-1:0]               en_o
);

   logic [SZ_W-1:0] code_cl;
   logic            unused_wbits;

   // Size codes beyond the largest window are folded onto it at write time.
   always_comb begin
      if (wr_data[SZ_W-1:0] > SZ_W'(SZ_MAX)) code_cl = SZ_W'(SZ_MAX);
      else                                   code_cl = wr_data[SZ_W-1:0];
   end

   assign unused_wbits = ^wr_data[GRAN_BITS-1:SZ_W+1];

   // Set-only flag: nothing but reset brings the boot mapping back.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  remap_o <= 1'b0;
      else if (wr_en && idx == '0 && wr_data[0])   remap_o <= 1'b1;
   end

   for (genvar g = 0; g < N_CS; g++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_o[g] <= '0;
            code_o[g] <= '0;
            en_o[g]   <= 1'b0;
         end else if (wr_en && idx == IDX_W'(g + 1)) begin
            base_o[g] <= wr_data[ADDR_W-1:GRAN_BITS];
            code_o[g] <= code_cl;
            en_o[g]   <= wr_data[SZ_W];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (idx == '0) begin
         rd_data[0] = remap_o;
      end else begin
         for (int k = 0; k < N_CS; k++) begin
            if (idx == IDX_W'(k + 1)) begin
               rd_data[ADDR_W-1:GRAN_BITS] = base_o[k];
               rd_data[SZ_W]               = en_o[k];
               rd_data[SZ_W-1:0]           = code_o[k];
            end
         end
      end
   end

endmodule

// File: rtl/bootmap_bank_match.sv
module bootmap_bank_match #(
   parameter int BASE_W = 12,
   parameter int SZ_W   = 3
) (
   input  logic [BASE_W-1:0] addr_hi,
   input  logic [BASE_W-1:0] base,
   input  logic [SZ_W-1:0]   code,
   input  logic              en,
   output logic              hit
);

   logic [BASE_W-1:0] mask;

   // Bits below the window size are don't-care in the comparison.
   always_comb begin
      for (int i = 0; i < BASE_W; i++) mask[i] = (i >= int'(code));
   end

   assign hit = en && (((addr_hi ^ base) & mask) == '0);

endmodule

// File: rtl/bootmap_decoder.sv
module bootmap_decoder
   import bootmap_pkg::*;
#(
   parameter int                 ADDR_W       = 32,
   parameter int                 N_CS         = 8,
   parameter int                 GRAN_BITS    = 20,
   parameter int                 SZ_W         = 3,
   parameter int                 SZ_MAX       = 4,
   parameter int                 INT_WIN_BITS = 20,
   parameter logic [ADDR_W-1:0]  SRAM_BASE    = 32'h0010_0000,
   parameter logic [ADDR_W-1:0]  BOOT_BASE    = 32'h0020_0000,
   parameter logic [ADDR_W-1:0]  EXT_LO       = 32'h0040_0000,
   parameter logic [ADDR_W-1:0]  EXT_HI       = 32'hFFC0_0000,
   parameter bit                 CS_LOW_WINS  = 1'b1,
   localparam int                BASE_W       = ADDR_W - GRAN_BITS,
   localparam int                IDX_W        = $clog2(N_CS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic               acc_fetch,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic               reg_wr,
   input  logic [IDX_W-1:0]   reg_idx,
   input  logic [ADDR_W-1:0]  reg_wdata,
   output logic [ADDR_W-1:0]  reg_rdata,
   output logic               sel_boot,
   output logic               sel_sram,
   output logic               sel_periph,
   output logic [N_CS-1:0]    cs_o,
   output logic               abt_prefetch,
   output logic               abt_data
);

   localparam int INT_TAG_W = ADDR_W - INT_WIN_BITS;

   // Elaboration-time parameter checks
   if (N_CS < 2 || N_CS > 16) begin : g_bad_ncs
      $error("N_CS must lie in 2..16");
   end
   if (GRAN_BITS <= SZ_W || GRAN_BITS >= ADDR_W) begin : g_bad_gran
      $error("GRAN_BITS must exceed SZ_W and be below ADDR_W");
   end
   if (SZ_MAX >= BASE_W || SZ_MAX >= (1 << SZ_W)) begin : g_bad_szmax
      $error("SZ_MAX must fit the size field and the base field");
   end
   if (EXT_LO >= EXT_HI) begin : g_bad_ext
      $error("EXT_LO must be below EXT_HI");
   end
   if (INT_WIN_BITS < 1 || INT_WIN_BITS >= ADDR_W) begin : g_bad_win
      $error("INT_WIN_BITS out of range");
   end

   logic                         remap_q;
   logic [N_CS-1:0][BASE_W-1:0]  bank_base;
   logic [N_CS-1:0][SZ_W-1:0]    bank_code;
   logic [N_CS-1:0]              bank_en;
   logic [N_CS-1:0]              raw_hit;
   logic [N_CS-1:0]              cs_allow;
   logic [N_CS-1:0]              cs_grant;
   int_rgn_t                     rgn;
   logic                         nxt_boot;
   logic                         nxt_sram;
   logic                         nxt_undef;

   bootmap_cfg_regs #(
      .ADDR_W    (ADDR_W),
      .N_CS      (N_CS),
      .GRAN_BITS (GRAN_BITS),
      .SZ_W      (SZ_W),
      .SZ_MAX    (SZ_MAX)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .idx     (reg_idx),
      .wr_data (reg_wdata),
      .rd_data (reg_rdata),
      .remap_o (remap_q),
      .base_o  (bank_base),
      .code_o  (bank_code),
      .en_o    (bank_en)
   );

   // Fixed internal windows and the external / peripheral split
   always_comb begin
      rgn        = '0;
      rgn.low    = (acc_addr[ADDR_W-1:INT_WIN_BITS] == '0);
      rgn.sram   = (acc_addr[ADDR_W-1:INT_WIN_BITS] == SRAM_BASE[ADDR_W-1:INT_WIN_BITS]);
      rgn.boot   = (acc_addr[ADDR_W-1:INT_WIN_BITS] == BOOT_BASE[ADDR_W-1:INT_WIN_BITS]);
      rgn.ext    = (acc_addr >= EXT_LO) && (acc_addr < EXT_HI);
      rgn.periph = (acc_addr >= EXT_HI);
   end

   for (genvar g = 0; g < N_CS; g++) begin : g_match
      bootmap_bank_match #(
         .BASE_W (BASE_W),
         .SZ_W   (SZ_W)
      ) u_match (
         .addr_hi (acc_addr[ADDR_W-1:GRAN_BITS]),
         .base    (bank_base[g]),
         .code    (bank_code[g]),
         .en      (bank_en[g]),
         .hit     (raw_hit[g])
      );
      // Bank 0 is reachable from reset; the rest wait for the remap command.
      if (g == 0) begin : g_boot_cs
         assign cs_allow[g] = raw_hit[g] && rgn.ext;
      end else begin : g_gated_cs
         assign cs_allow[g] = raw_hit[g] && rgn.ext && remap_q;
      end
   end

   if (CS_LOW_WINS) begin : g_pri_low
      assign cs_grant = cs_allow & (~cs_allow + 1'b1);
   end else begin : g_pri_high
      always_comb begin
         logic found;
         found    = 1'b0;
         cs_grant = '0;
         for (int k = N_CS - 1; k >= 0; k--) begin
            if (cs_allow[k] && !found) begin
               cs_grant[k] = 1'b1;
               found       = 1'b1;
            end
         end
      end
   end

   assign nxt_boot  = (rgn.low && !remap_q) || rgn.boot;
   assign nxt_sram  = (rgn.low &&  remap_q) || rgn.sram;
   assign nxt_undef = rgn.ext && (cs_allow == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_boot     <= 1'b0;
         sel_sram     <= 1'b0;
         sel_periph   <= 1'b0;
         cs_o         <= '0;
         abt_prefetch <= 1'b0;
         abt_data     <= 1'b0;
      end else begin
         sel_boot     <= acc_valid && nxt_boot;
         sel_sram     <= acc_valid && nxt_sram;
         sel_periph   <= acc_valid && rgn.periph;
         cs_o         <= acc_valid ? cs_grant : '0;
         abt_prefetch <= acc_valid && nxt_undef &&  acc_fetch;
         abt_data     <= acc_valid && nxt_undef && !acc_fetch;
      end
   end

endmodule

// File: rtl/bootmap_decoder_chk.sv
module bootmap_decoder_chk #(
   parameter int ADDR_W = 32,
   parameter int N_CS   = 8,
   parameter int IDX_W  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               remap,
   input logic               acc_valid,
   input logic               reg_wr,
   input logic [IDX_W-1:0]   reg_idx,
   input logic [ADDR_W-1:0]  reg_wdata,
   input logic               sel_boot,
   input logic               sel_sram,
   input logic               sel_periph,
   input logic [N_CS-1:0]    cs_o,
   input logic               abt_prefetch,
   input logic               abt_data
);

   // R2: the command bit sets the flag at the next edge
   p_set_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_idx == '0 && reg_wdata[0]) |=> remap);

   // R3: the flag never clears while reset is high
   p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      remap |=> remap);

   // R4: upper chip selects stay low before remap
   p_cs_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !remap |-> (cs_o[N_CS-1:1] == '0));

   // R5: at most one bank wins
   p_cs_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_o));

   // R6: the two abort kinds never coincide
   p_abort_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(abt_prefetch && abt_data));

   // R1: at most one destination per access
   p_one_dest_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_boot, sel_sram, sel_periph, |cs_o, abt_prefetch | abt_data}));

   // R8: nothing is asserted after an edge without a valid access
   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (!sel_boot && !sel_sram && !sel_periph && cs_o == '0
                      && !abt_prefetch && !abt_data));

endmodule

bind bootmap_decoder bootmap_decoder_chk #(
   .ADDR_W (ADDR_W),
   .N_CS   (N_CS),
   .IDX_W  (IDX_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .remap        (remap_q),
   .acc_valid    (acc_valid),
   .reg_wr       (reg_wr),
   .reg_idx      (reg_idx),
   .reg_wdata    (reg_wdata),
   .sel_boot     (sel_boot),
   .sel_sram     (sel_sram),
   .sel_periph   (sel_periph),
   .cs_o         (cs_o),
   .abt_prefetch (abt_prefetch),
   .abt_data     (abt_data)
);

// File: tb/bootmap_decoder_test.sv
`timescale 1ns/1ps
module bootmap_decoder_test;

   // Packed output view: {boot, sram, periph, cs[7:0], abt_pf, abt_data}
   localparam logic [12:0] E_NONE = 13'h0000;
   localparam logic [12:0] E_BOOT = 13'h1000;
   localparam logic [12:0] E_SRAM = 13'h0800;
   localparam logic [12:0] E_PER  = 13'h0400;
   localparam logic [12:0] E_CS0  = 13'h0004;
   localparam logic [12:0] E_CS1  = 13'h0008;
   localparam logic [12:0] E_CS3  = 13'h0020;
   localparam logic [12:0] E_APF  = 13'h0002;
   localparam logic [12:0] E_ADT  = 13'h0001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_fetch = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_idx = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        sel_boot, sel_sram, sel_periph, abt_prefetch, abt_data;
   logic [7:0]  cs_o;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   bootmap_decoder uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .acc_valid    (acc_valid),
      .acc_fetch    (acc_fetch),
      .acc_addr     (acc_addr),
      .reg_wr       (reg_wr),
      .reg_idx      (reg_idx),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .sel_boot     (sel_boot),
      .sel_sram     (sel_sram),
      .sel_periph   (sel_periph),
      .cs_o         (cs_o),
      .abt_prefetch (abt_prefetch),
      .abt_data     (abt_data)
   );

   function automatic logic [12:0] outs();
      return {sel_boot, sel_sram, sel_periph, cs_o, abt_prefetch, abt_data};
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      acc_valid = 1'b0;
      reg_wr = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic acc(input logic [31:0] a, input logic f, input logic [12:0] exp, input string tag);
      @(negedge clk);
      acc_addr  = a;
      acc_fetch = f;
      acc_valid = 1'b1;
      @(posedge clk);
      #1;
      check(32'(outs()), 32'(exp), tag);
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic wr(input logic [3:0] i, input logic [31:0] d);
      @(negedge clk);
      reg_idx   = i;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [3:0] i, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_idx = i;
      #1;
      check(reg_rdata, exp, tag);
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      check(32'(outs()), 32'(E_NONE), "R10 outputs after reset");
      rd(4'd0, 32'h0, "R10 remap flag after reset");
      rd(4'd2, 32'h0, "R10 bank register after reset");
   endtask

   task automatic t_internal_pre();
      acc(32'h0000_0020, 1'b1, E_BOOT, "R1 vector before remap");
      acc(32'h000F_FFFC, 1'b0, E_BOOT, "R1 top of low window before remap");
      acc(32'h0010_0000, 1'b0, E_SRAM, "R9 fixed SRAM window");
      acc(32'h0020_0004, 1'b0, E_BOOT, "R9 fixed boot window");
      acc(32'h0030_0000, 1'b1, E_NONE, "R9 R7 internal hole no abort");
   endtask

   task automatic t_bank_prog();
      wr(4'd1, 32'h0040_0008);          // bank0: 1 MiB at 0x0040_0000
      wr(4'd2, 32'h0100_FFFA);          // bank1: 4 MiB at 0x0100_0000, junk bits
      rd(4'd2, 32'h0100_000A, "R5 bank readback masks unused bits");
      wr(4'd4, 32'h0200_000F);          // bank3: code 7 folded to 4 (16 MiB)
      rd(4'd4, 32'h0200_000C, "R5 size code clamp");
   endtask

   task automatic t_pre_remap_ext();
      acc(32'h0040_0010, 1'b0, E_CS0, "R4 cs0 usable before remap");
      acc(32'h0120_0000, 1'b0, E_ADT, "R4 R6 blocked bank data abort");
      acc(32'h0120_0000, 1'b1, E_APF, "R4 R6 blocked bank prefetch abort");
      acc(32'h0080_0000, 1'b0, E_ADT, "R6 unmapped external data abort");
      acc(32'hFFC0_0000, 1'b0, E_PER, "R7 peripheral base");
      acc(32'hFFFF_FFFC, 1'b1, E_PER, "R7 peripheral top fetch");
      acc(32'h003F_FFFC, 1'b0, E_NONE, "R7 just below external space");
   endtask

   task automatic t_remap();
      wr(4'd0, 32'h0);
      rd(4'd0, 32'h0, "R2 zero write has no effect");
      acc(32'h0000_0000, 1'b0, E_BOOT, "R2 still boot after zero write");
      wr(4'd0, 32'h1);
      rd(4'd0, 32'h1, "R2 flag readback after set");
      acc(32'h0000_0020, 1'b1, E_SRAM, "R1 vector after remap");
      acc(32'h0020_0000, 1'b0, E_BOOT, "R9 boot window after remap");
      acc(32'h0120_0000, 1'b0, E_CS1, "R4 bank1 enabled after remap");
      acc(32'h013F_FFFC, 1'b0, E_CS1, "R5 top of 4 MiB window");
      acc(32'h0140_0000, 1'b1, E_APF, "R5 R6 just past window");
      wr(4'd0, 32'h0);
      wr(4'd5, 32'h0000_0001);
      rd(4'd0, 32'h1, "R3 flag survives writes");
   endtask

   task automatic t_overlap();
      wr(4'd3, 32'h0100_0008);          // bank2: 1 MiB at 0x0100_0000 overlaps bank1
      acc(32'h0100_0000, 1'b0, E_CS1, "R5 lowest index wins");
      acc(32'h02FF_FFFC, 1'b0, E_CS3, "R5 clamped 16 MiB window top");
      acc(32'h0300_0000, 1'b0, E_ADT, "R5 R6 past clamped window");
   endtask

   task automatic t_pulse();
      acc(32'h0080_0000, 1'b0, E_ADT, "R8 abort raised");
      @(posedge clk);
      #1;
      check(32'(outs()), 32'(E_NONE), "R8 abort is one cycle");
   endtask

   task automatic t_reset_again();
      do_reset();
      rd(4'd0, 32'h0, "R3 reset clears flag");
      rd(4'd2, 32'h0, "R10 bank cleared by reset");
      acc(32'h0000_0020, 1'b0, E_BOOT, "R3 boot mapping restored");
      acc(32'h0040_0010, 1'b0, E_ADT, "R10 disabled bank aborts");
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      do_reset();
      t_reset_state();
      t_internal_pre();
      t_bank_prog();
      t_pre_remap_ext();
      t_remap();
      t_overlap();
      t_pulse();
      t_reset_again();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule